// File: doc/BRIEF.md
# Interlocked Cam Switch Scan Decoder

This block reads a bank of six cam switches that a mechanical interlock keeps mutually exclusive. The switches share one three-state drive line and two sense lines, joined through an external diode and resistor network. On request the block runs a two-phase scan. It first drives the line high, waits a programmable settle time and samples both sense lines. It then drives the line low, waits the same settle time and samples again. Between scans the drive line is released, so the network draws no current.

The drive line is presented as an output-enable and an output-value pair, which feed a pad buffer outside the block. Each of the two samples is decoded against the pattern table for its drive polarity. The result is a 3-bit switch index, with 0 meaning that no switch is closed. An error flag is raised when both phases show a closed switch, which a healthy interlocked bank cannot produce. A one-cycle valid pulse marks each fresh result, and the result stays held until the next scan completes.

Top module: `cam_scan_decoder`

## Requirements
- R1: After reset and whenever no scan is running, drive_oe is 0; reset clears sw_index, result_err and result_valid to 0.
- R2: A scan_req seen while idle starts a scan. For settle+1 cycles drive_oe=1 with drive_val=1, then for settle+1 cycles drive_oe=1 with drive_val=0, then drive_oe returns to 0.
- R3: The settle value is captured when the scan starts. Changing settle_cycles during a scan does not change the length of either phase.
- R4: The sample from the high phase, written as {sense_a,sense_b}, decodes 10 to switch 1, 01 to switch 3 and 11 to switch 5. The pattern 00 is not a match.
- R5: The sample from the low phase decodes 01 to switch 2, 10 to switch 4 and 00 to switch 6. The pattern 11 is not a match.
- R6: When exactly one phase matches, sw_index is that switch and result_err is 0. When neither phase matches, sw_index is 0 and result_err is 0.
- R7: When both phases match, result_err is 1 and sw_index is 0.
- R8: result_valid is 1 for exactly one cycle per scan, in the first cycle after the drive is released. sw_index and result_err hold their values until the next valid pulse.
- R9: A scan_req that arrives while a scan is running is ignored. It neither restarts nor extends the scan, and it does not queue a second scan.
- R10: The sense lines are sampled only in the last cycle of each phase. Their values while the drive is released have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_req | input | 1 | Start a scan (taken only when idle) |
| settle_cycles | input | SETTLE_W | Extra wait cycles per phase before sampling |
| sense_a | input | 1 | First sense line |
| sense_b | input | 1 | Second sense line |
| drive_oe | output | 1 | Drive line output enable (0 = high impedance) |
| drive_val | output | 1 | Drive line level while enabled |
| sw_index | output | 3 | Closed switch 1..6, or 0 for none or error |
| result_valid | output | 1 | One-cycle pulse marking a new result |
| result_err | output | 1 | Both phases matched |

## Verification
The error outcome cannot come from any single closed switch, so the bench network model has a fault mode. In this mode the sense pair is set independently for each drive polarity, and random pairs often produce a match in both phases. Requests made in the middle of a scan, and changes to settle_cycles in the middle of a scan, are driven from inside the phase-counting loop. While the drive is released, the sense lines carry random junk, so any sampling outside the two phase windows would corrupt the decoded index.

// File: rtl/cam_scan_pkg.sv
package cam_scan_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } scan_state_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } phase_hit_t;
endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import cam_scan_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scan_req,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                drive_oe,
  output logic                drive_val,
  output logic                sample_hi,
  output logic                sample_lo
);
  scan_state_e         state_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic [SETTLE_W-1:0] settle_q;
  logic                phase_end;

  assign phase_end = (cnt_q == settle_q);
  assign sample_hi = (state_q == ST_HIGH) && phase_end;
  assign sample_lo = (state_q == ST_LOW) && phase_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      settle_q  <= '0;
      drive_oe  <= 1'b0;
      drive_val <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (scan_req) begin
            state_q   <= ST_HIGH;
            settle_q  <= settle_cycles;
            cnt_q     <= '0;
            drive_oe  <= 1'b1;
            drive_val <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (phase_end) begin
            state_q   <= ST_LOW;
            cnt_q     <= '0;
            drive_val <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_LOW: begin
          if (phase_end) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            drive_oe <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: each scan begins with the high phase
  assert_high_first_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_oe) |-> drive_val);

  // R1: the drive is released right after the low-phase sample
  assert_release_after_low_R1: assert property (@(posedge clk) disable iff (rst)
    sample_lo |=> !drive_oe);

  // R2: the low phase always follows the high-phase sample
  assert_low_follows_high_R2: assert property (@(posedge clk) disable iff (rst)
    sample_hi |=> (drive_oe && !drive_val));

  // R3: the captured settle value does not move during a scan
  assert_settle_held_R3: assert property (@(posedge clk) disable iff (rst)
    (drive_oe && !$rose(drive_oe)) |-> $stable(settle_q));
endmodule

// File: rtl/phase_decoder.sv
module phase_decoder
  import cam_scan_pkg::*;
#(
  parameter bit HIGH_PHASE = 1'b1
) (
  input  logic [1:0] sense,
  output phase_hit_t result
);
  generate
    if (HIGH_PHASE) begin : g_high
      always_comb begin
        result = '0;
        unique case (sense)
          2'b10:   result = '{hit: 1'b1, idx: IDX_W'(1)};
          2'b01:   result = '{hit: 1'b1, idx: IDX_W'(3)};
          2'b11:   result = '{hit: 1'b1, idx: IDX_W'(5)};
          default: result = '0;
        endcase
      end
    end else begin : g_low
      always_comb begin
        result = '0;
        unique case (sense)
          2'b01:   result = '{hit: 1'b1, idx: IDX_W'(2)};
          2'b10:   result = '{hit: 1'b1, idx: IDX_W'(4)};
          2'b00:   result = '{hit: 1'b1, idx: IDX_W'(6)};
          default: result = '0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/result_register.sv
module result_register
  import cam_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_hi,
  input  logic             sample_lo,
  input  phase_hit_t       hi_now,
  input  phase_hit_t       lo_now,
  output logic [IDX_W-1:0] sw_index,
  output logic             result_err,
  output logic             result_valid
);
  phase_hit_t hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q         <= '0;
      sw_index     <= '0;
      result_err   <= 1'b0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= sample_lo;
      if (sample_hi) begin
        hi_q <= hi_now;
      end
      if (sample_lo) begin
        if (hi_q.hit && lo_now.hit) begin
          sw_index   <= '0;
          result_err <= 1'b1;
        end else begin
          sw_index   <= hi_q.hit ? hi_q.idx : (lo_now.hit ? lo_now.idx : '0);
          result_err <= 1'b0;
        end
      end
    end
  end

  // R8: valid lasts a single cycle
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  // R7: an error never carries a switch index
  assert_err_no_index_R7: assert property (@(posedge clk) disable iff (rst)
    result_err |-> (sw_index == '0));

  // R8: result holds between valid pulses
  assert_result_held_R8: assert property (@(posedge clk) disable iff (rst)
    (!result_valid && !$past(sample_lo)) |-> ($stable(sw_index) && $stable(result_err)));
endmodule

// File: rtl/cam_scan_decoder.sv
module cam_scan_decoder
  import cam_scan_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scan_req,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                sense_a,
  input  logic                sense_b,
  output logic                drive_oe,
  output logic                drive_val,
  output logic [2:0]          sw_index,
  output logic                result_valid,
  output logic                result_err
);
  logic       sample_hi;
  logic       sample_lo;
  logic [1:0] sense_pair;
  phase_hit_t hi_now;
  phase_hit_t lo_now;

  assign sense_pair = {sense_a, sense_b};

  scan_sequencer #(.SETTLE_W(SETTLE_W)) seq_i (
    .clk          (clk),
    .rst          (rst),
    .scan_req     (scan_req),
    .settle_cycles(settle_cycles),
    .drive_oe     (drive_oe),
    .drive_val    (drive_val),
    .sample_hi    (sample_hi),
    .sample_lo    (sample_lo)
  );

  phase_decoder #(.HIGH_PHASE(1'b1)) dec_hi_i (
    .sense (sense_pair),
    .result(hi_now)
  );

  phase_decoder #(.HIGH_PHASE(1'b0)) dec_lo_i (
    .sense (sense_pair),
    .result(lo_now)
  );

  result_register res_i (
    .clk         (clk),
    .rst         (rst),
    .sample_hi   (sample_hi),
    .sample_lo   (sample_lo),
    .hi_now      (hi_now),
    .lo_now      (lo_now),
    .sw_index    (sw_index),
    .result_err  (result_err),
    .result_valid(result_valid)
  );

  // R6: the index never leaves the range 0..6
  assert_index_range_R6: assert property (@(posedge clk) disable iff (rst)
    sw_index <= 3'd6);

  // R8: a result appears only once the drive is released
  assert_valid_when_released_R8: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !drive_oe);

  // R2: release happens only from the low phase
  assert_release_from_low_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_oe) |-> !$past(drive_val));

  // R1: valid follows the end of a scan
  assert_valid_after_scan_R1: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $past(drive_oe));
endmodule

// File: tb/cam_scan_decoder_tb_top.sv
module cam_scan_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          scan_req;
  logic [SW-1:0] settle_cycles;
  logic          sense_a, sense_b;
  logic          drive_oe, drive_val;
  logic [2:0]    sw_index;
  logic          result_valid, result_err;

  int         checks = 0;
  int         fails = 0;
  bit         done = 0;
  int         closed_sw = 0;
  bit         fault = 0;
  logic [1:0] fault_hi = 2'b00;
  logic [1:0] fault_lo = 2'b11;
  logic [1:0] junk = 2'b10;
  int unsigned seed_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_scan_decoder #(.SETTLE_W(SW)) dut_i (
    .clk(clk), .rst(rst), .scan_req(scan_req), .settle_cycles(settle_cycles),
    .sense_a(sense_a), .sense_b(sense_b), .drive_oe(drive_oe), .drive_val(drive_val),
    .sw_index(sw_index), .result_valid(result_valid), .result_err(result_err));

  // Network model: the pattern seen for the closed switch and the drive level
  function automatic logic [1:0] net_model(int sw, logic lvl);
    if (lvl) begin
      case (sw)
        1: return 2'b10;
        3: return 2'b01;
        5: return 2'b11;
        default: return 2'b00;
      endcase
    end else begin
      case (sw)
        2: return 2'b01;
        4: return 2'b10;
        6: return 2'b00;
        default: return 2'b11;
      endcase
    end
  endfunction

  // Expected {err, index} from the requirement tables (R4, R5, R6, R7)
  function automatic logic [3:0] expect_res(logic [1:0] h, logic [1:0] l);
    logic [2:0] hi_idx, lo_idx;
    case (h)
      2'b10: hi_idx = 3'd1;
      2'b01: hi_idx = 3'd3;
      2'b11: hi_idx = 3'd5;
      default: hi_idx = 3'd0;
    endcase
    case (l)
      2'b01: lo_idx = 3'd2;
      2'b10: lo_idx = 3'd4;
      2'b00: lo_idx = 3'd6;
      default: lo_idx = 3'd0;
    endcase
    if (hi_idx != 0 && lo_idx != 0) return 4'b1000;
    return {1'b0, hi_idx | lo_idx};
  endfunction

  always_comb begin
    if (!drive_oe) {sense_a, sense_b} = junk;
    else if (fault) {sense_a, sense_b} = drive_val ? fault_hi : fault_lo;
    else {sense_a, sense_b} = net_model(closed_sw, drive_val);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_scan(input int sw, input bit flt, input logic [1:0] fh,
                          input logic [1:0] fl, input int s, input bit mid_req,
                          input bit mid_settle);
    int hc, lc, g;
    logic [1:0] eh, el;
    logic [3:0] expv;
    logic [2:0] held;
    @(negedge clk);
    check(drive_oe == 1'b0, "R1 idle release", drive_oe, 0);
    closed_sw = sw; fault = flt; fault_hi = fh; fault_lo = fl;
    junk = 2'($urandom);
    settle_cycles = SW'(s);
    scan_req = 1'b1;
    @(negedge clk);
    scan_req = 1'b0;
    hc = 0; lc = 0; g = 0;
    while (drive_oe && drive_val && g < 600) begin
      hc++; g++;
      scan_req = (mid_req && hc == 1);
      if (mid_settle && hc == 1) settle_cycles = SW'(s + 3);
      @(negedge clk);
    end
    scan_req = 1'b0;
    while (drive_oe && !drive_val && g < 1200) begin
      lc++; g++;
      scan_req = (mid_req && lc == 1);
      @(negedge clk);
    end
    scan_req = 1'b0;
    check(hc == s + 1, mid_settle ? "R3 high length" : "R2 high length", hc, s + 1);
    check(lc == s + 1, mid_settle ? "R3 low length" : "R2 low length", lc, s + 1);
    eh = flt ? fh : net_model(sw, 1'b1);
    el = flt ? fl : net_model(sw, 1'b0);
    expv = expect_res(eh, el);
    check(result_valid == 1'b1, "R8 valid after release", result_valid, 1);
    check(sw_index == expv[2:0],
          expv[3] ? "R7 index" : (flt ? "R6 index" : "R4/R5 index R10"),
          sw_index, expv[2:0]);
    check(result_err == expv[3], expv[3] ? "R7 err" : "R6 err", result_err, expv[3]);
    held = sw_index;
    junk = ~junk;
    @(negedge clk);
    check(result_valid == 1'b0, "R8 single pulse", result_valid, 0);
    check(sw_index == held, "R8 hold", sw_index, held);
    if (mid_req) begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        check(drive_oe == 1'b0 && result_valid == 1'b0, "R9 no extra scan",
              {drive_oe, result_valid}, 0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    seed_val = $urandom(32'd1234);
    rst = 1'b1; scan_req = 1'b0; settle_cycles = '0;
    repeat (3) @(negedge clk);
    check(drive_oe == 0, "R1 reset oe", drive_oe, 0);
    check(result_valid == 0, "R1 reset valid", result_valid, 0);
    check(sw_index == 0, "R1 reset index", sw_index, 0);
    check(result_err == 0, "R1 reset err", result_err, 0);
    rst = 1'b0;
    for (int sw = 0; sw <= 6; sw++) run_scan(sw, 0, 2'b00, 2'b11, 0, 0, 0);
    run_scan(5, 0, 2'b00, 2'b11, 20, 0, 0);
    run_scan(2, 1, 2'b10, 2'b01, 1, 0, 0);
    run_scan(0, 1, 2'b00, 2'b11, 2, 0, 0);
    run_scan(0, 1, 2'b11, 2'b00, 0, 0, 0);
    run_scan(3, 0, 2'b00, 2'b11, 4, 1, 0);
    run_scan(4, 0, 2'b00, 2'b11, 2, 0, 1);
    for (int n = 0; n < 80; n++) begin
      if ($urandom_range(0, 2) == 0)
        run_scan(0, 1, 2'($urandom), 2'($urandom), $urandom_range(0, 6),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
      else
        run_scan($urandom_range(0, 6), 0, 2'b00, 2'b11, $urandom_range(0, 6),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule